// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block collects interrupt requests from up to 32 peripheral sources and hands a single interrupt line to a host processor. Every source is level-sensitive and is captured into a pending register each clock. A per-source enable mask and a set of in-service bits together decide which requests count as eligible. A global enable gates the request line that goes up to the host. The host serves a request in three steps. It writes the acknowledge bit of the vector register, reads the winning vector number from the upper bits of that register, and later retires the service by writing that vector's bit to the in-service register.

The priority order is source index by default, and a higher index wins. Configuration can change this order in two ways. One field promotes any single source above all others. Four 2-bit slot fields reorder a block of four serial-channel sources among themselves. Vector 0 is reserved. Input 0 is ignored, and vector 0 is what an acknowledge returns when no eligible source is left. This happens, for example, when software masks a source in the same moment the source raises its request. Such an empty acknowledge marks vector 0 in service and raises a separate error interrupt. That error interrupt is cleared by the usual end-of-service write.

Top module: `cic_ctrl`

## Requirements
- R1: After reset the mask, in-service and vector registers read 0, the configuration reads 0xE4000000 (identity slot order, no promoted source, global enable off), and both `irq_o` and `err_irq_o` are low.
- R2: The pending register (address 2, read-only) shows the source levels registered on the previous clock. Bit 0 always reads 0, and a pending bit falls again when its source falls.
- R3: Mask register (address 1): when bit v is 1, source v is enabled; when it is 0, source v is excluded from `irq_o` and from acknowledge.
- R4: Configuration bit 7 is the global enable. `irq_o` is high only when this bit is 1 and at least one eligible source exists.
- R5: Writing address 4 with bit 0 set is an acknowledge. It latches the winning vector, and a read of address 4 then returns that vector in bits 15:11 with all other bits 0. A write to address 4 with bit 0 clear changes nothing.
- R6: With no promotion and identity slot order, the eligible source with the highest index wins.
- R7: Configuration bits 17:13 name a promoted source that ranks above all others. The value 0 promotes nothing.
- R8: Sources CH_BASE..CH_BASE+3 are channels 0..3. The 2-bit field at configuration bits 24+2s (s = 0..3) names the channel that holds rank CH_BASE+s, so slot 3 is the highest of the four.
- R9: An acknowledge sets the in-service bit of the returned vector. A source is eligible only if its rank is strictly above the rank of every in-service source.
- R10: Writing a word to the in-service register (address 3) clears exactly the bits that are 1 in the word and leaves all other bits unchanged.
- R11: An acknowledge that finds no eligible source returns vector 0 and sets in-service bit 0. `err_irq_o` follows that bit, whatever the global enable. Vector 0 never holds off any other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive source requests (bit 0 unused) |
| reg_addr | input | 3 | Register word address: 0 config, 1 mask, 2 pending, 3 in-service, 4 vector |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt request to the host |
| err_irq_o | output | 1 | Error interrupt after an empty acknowledge |

## Verification
The bench builds the block with its defaults: 32 sources and the channel group at 26..29. This makes the promoted-source field reach every legal vector and lets the channel slots clash with plain high-index sources such as 30 and 31. Random slot permutations and promoted sources are mixed with nested acknowledges. The bench therefore reaches cases where a channel ranks below or above a plain source, and where an in-service channel holds off a higher-numbered source. Directed steps cover the masked race that ends in vector 0 and its clearance through in-service bit 0.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int VEC_W  = 5;
    localparam int RANK_W = VEC_W + 1;
    localparam int NUM_CH = 4;

    localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(32);

    localparam logic [2:0] A_CFG   = 3'd0;
    localparam logic [2:0] A_MASK  = 3'd1;
    localparam logic [2:0] A_PEND  = 3'd2;
    localparam logic [2:0] A_INSVC = 3'd3;
    localparam logic [2:0] A_VEC   = 3'd4;

    localparam logic [31:0] CFG_WMASK = 32'hFF03_E080;
    localparam logic [31:0] CFG_RESET = 32'hE400_0000;

    typedef struct packed {
        logic [NUM_CH-1:0][1:0] slot;     // 31:24, slot s at 24+2s
        logic [5:0]             rsv_a;    // 23:18
        logic [VEC_W-1:0]       top_src;  // 17:13
        logic [4:0]             rsv_b;    // 12:8
        logic                   gie;      // 7
        logic [6:0]             rsv_c;    // 6:0
    } cfg_t;

endpackage

// File: rtl/cic_rank.sv
module cic_rank
    import cic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CH_BASE = 26
) (
    input  cfg_t                          cfg,
    output logic [NUM_SRC-1:0][RANK_W-1:0] rank
);

    // position of each channel inside the slot group
    logic [NUM_CH-1:0][1:0] ch_pos;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ch_pos[c] = 2'(c);
            for (int s = 0; s < NUM_CH; s++) begin
                if (cfg.slot[s] == 2'(c)) begin
                    ch_pos[c] = 2'(s);
                end
            end
        end
    end

    for (genvar v = 0; v < NUM_SRC; v++) begin : g_src
        if (v >= CH_BASE && v < CH_BASE + NUM_CH) begin : g_chan
            assign rank[v] = (v != 0 && cfg.top_src == VEC_W'(v)) ? TOP_RANK
                           : RANK_W'(CH_BASE) + RANK_W'(ch_pos[v-CH_BASE]);
        end else begin : g_plain
            assign rank[v] = (v != 0 && cfg.top_src == VEC_W'(v)) ? TOP_RANK
                           : RANK_W'(v);
        end
    end

endmodule

// File: rtl/cic_arbiter.sv
module cic_arbiter
    import cic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             mask,
    input  logic [NUM_SRC-1:0]             insvc,
    input  logic [NUM_SRC-1:0][RANK_W-1:0] rank,
    output logic [NUM_SRC-1:0]             elig,
    output logic                           any_elig,
    output logic [VEC_W-1:0]               win
);

    logic [RANK_W-1:0] ceil_r;
    logic [RANK_W-1:0] best;

    // highest rank currently in service (vector 0 ranks 0 and blocks nothing)
    always_comb begin
        ceil_r = '0;
        for (int v = 1; v < NUM_SRC; v++) begin
            if (insvc[v] && rank[v] > ceil_r) begin
                ceil_r = rank[v];
            end
        end
    end

    for (genvar v = 0; v < NUM_SRC; v++) begin : g_elig
        if (v == 0) begin : g_rsv
            assign elig[v] = 1'b0;
        end else begin : g_src
            assign elig[v] = pend[v] & mask[v] & (rank[v] > ceil_r);
        end
    end

    assign any_elig = |elig;

    always_comb begin
        win  = '0;
        best = '0;
        for (int v = 1; v < NUM_SRC; v++) begin
            if (elig[v] && rank[v] >= best) begin
                best = rank[v];
                win  = VEC_W'(v);
            end
        end
    end

endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl
    import cic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CH_BASE = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [2:0]         reg_addr,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_o,
    output logic               err_irq_o
);

    typedef struct packed {
        cfg_t               cfg;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] insvc;
        logic [VEC_W-1:0]   vec;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0][RANK_W-1:0] rank;
    logic [NUM_SRC-1:0]             elig;
    logic                           any_elig;
    logic [VEC_W-1:0]               win;

    cic_rank #(.NUM_SRC(NUM_SRC), .CH_BASE(CH_BASE)) u_rank (
        .cfg  (st_q.cfg),
        .rank (rank)
    );

    cic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend     (st_q.pend),
        .mask     (st_q.mask),
        .insvc    (st_q.insvc),
        .rank     (rank),
        .elig     (elig),
        .any_elig (any_elig),
        .win      (win)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pend    = src_i;
        st_d.pend[0] = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                A_CFG:   st_d.cfg   = cfg_t'(reg_wdata & CFG_WMASK);
                A_MASK:  st_d.mask  = reg_wdata[NUM_SRC-1:0];
                A_INSVC: st_d.insvc = st_q.insvc & ~reg_wdata[NUM_SRC-1:0];
                A_VEC: begin
                    if (reg_wdata[0]) begin
                        st_d.vec        = win;
                        st_d.insvc[win] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg   <= cfg_t'(CFG_RESET);
            st_q.mask  <= '0;
            st_q.pend  <= '0;
            st_q.insvc <= '0;
            st_q.vec   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CFG:   reg_rdata = 32'(st_q.cfg);
            A_MASK:  reg_rdata = 32'(st_q.mask);
            A_PEND:  reg_rdata = 32'(st_q.pend);
            A_INSVC: reg_rdata = 32'(st_q.insvc);
            A_VEC:   reg_rdata = {16'b0, st_q.vec, 11'b0};
            default: reg_rdata = '0;
        endcase
    end

    assign irq_o     = st_q.cfg.gie & any_elig;
    assign err_irq_o = st_q.insvc[0];

endmodule

// File: rtl/cic_ctrl_chk.sv
module cic_ctrl_chk
    import cic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [2:0]         reg_addr,
    input logic               reg_we,
    input logic [31:0]        reg_wdata,
    input logic               irq_o,
    input logic               err_irq_o,
    input logic               gie,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] insvc,
    input logic [VEC_W-1:0]   vec
);

    assert_pend_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend == ($past(src_i) & ~NUM_SRC'(1)));

    assert_gie_gates_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie);

    assert_ack_marks_insvc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_VEC && reg_wdata[0]) |=> insvc[vec]);

    assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_INSVC) |=>
            ((insvc & $past(reg_wdata[NUM_SRC-1:0])) == '0));

    assert_err_vec_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq_o) |-> vec == '0);

endmodule

bind cic_ctrl cic_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .err_irq_o (err_irq_o),
    .gie       (st_q.cfg.gie),
    .pend      (st_q.pend),
    .insvc     (st_q.insvc),
    .vec       (st_q.vec)
);

// File: tb/cic_ctrl_test.sv
module cic_ctrl_test;
    import cic_pkg::*;

    localparam int NS = 32;
    localparam int CB = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic [2:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_o, err_irq_o;

    always #5 clk = ~clk;

    cic_ctrl #(.NUM_SRC(NS), .CH_BASE(CB)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .err_irq_o(err_irq_o)
    );

    int total = 0;
    int bad   = 0;

    logic [31:0] m_cfg, m_mask, m_pend, m_insvc;
    logic [4:0]  m_vec;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int mrank(int v);
        int hp = int'(m_cfg[17:13]);
        if (v != 0 && v == hp) return 32;
        if (v >= CB && v < CB + 4) begin
            for (int s = 3; s >= 0; s--)
                if (int'(m_cfg[24+2*s +: 2]) == v - CB) return CB + s;
        end
        return v;
    endfunction

    function automatic int mceil();
        int c = 0;
        for (int v = 1; v < NS; v++)
            if (m_insvc[v] && mrank(v) > c) c = mrank(v);
        return c;
    endfunction

    function automatic bit mok(int v);
        return m_pend[v] && m_mask[v] && (mrank(v) > mceil());
    endfunction

    function automatic int mwin();
        int w = 0;
        int b = 0;
        for (int v = 1; v < NS; v++)
            if (mok(v) && mrank(v) >= b) begin
                b = mrank(v);
                w = v;
            end
        return w;
    endfunction

    function automatic bit many();
        for (int v = 1; v < NS; v++)
            if (mok(v)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        case (a)
            A_CFG:   m_cfg   = d & CFG_WMASK;
            A_MASK:  m_mask  = d;
            A_INSVC: m_insvc = m_insvc & ~d;
            A_VEC: if (d[0]) begin
                int w;
                w = mwin();
                m_vec = 5'(w);
                m_insvc[w] = 1'b1;
            end
            default: ;
        endcase
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic setsrc(input logic [31:0] s);
        @(negedge clk);
        src_i  = s;
        m_pend = s & ~32'd1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        @(negedge clk);
        chk({tag, " R4 irq"}, 32'(irq_o), 32'(m_cfg[7] & many()));
        chk({tag, " R11 err"}, 32'(err_irq_o), 32'(m_insvc[0]));
        rd(A_INSVC, d); chk({tag, " R9 insvc"}, d, m_insvc);
        rd(A_VEC, d);   chk({tag, " R5 vec"}, d, {16'b0, m_vec, 11'b0});
        rd(A_PEND, d);  chk({tag, " R2 pend"}, d, m_pend);
        rd(A_MASK, d);  chk({tag, " R3 mask"}, d, m_mask);
        rd(A_CFG, d);   chk({tag, " R7 cfg"}, d, m_cfg);
    endtask

    function automatic logic [7:0] rand_perm();
        int p [4];
        logic [7:0] r;
        for (int i = 0; i < 4; i++) p[i] = i;
        for (int i = 3; i > 0; i--) begin
            int j = int'($urandom % (i + 1));
            int t = p[i];
            p[i] = p[j];
            p[j] = t;
        end
        for (int i = 0; i < 4; i++) r[2*i +: 2] = 2'(p[i]);
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        m_cfg = CFG_RESET; m_mask = 0; m_pend = 0; m_insvc = 0; m_vec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CFG, d);   chk("R1 cfg", d, 32'hE400_0000);
        rd(A_MASK, d);  chk("R1 mask", d, 0);
        rd(A_INSVC, d); chk("R1 insvc", d, 0);
        rd(A_VEC, d);   chk("R1 vec", d, 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 err", 32'(err_irq_o), 0);

        // R3/R4: enabled sources, global enable off then on
        setsrc(32'h0000_0221);
        wr(A_MASK, 32'h0000_0220);
        check_all("d1");
        chk("R4 irq off", 32'(irq_o), 0);
        wr(A_CFG, 32'hE400_0080);
        check_all("d2");
        chk("R3 irq on", 32'(irq_o), 1);
        rd(A_PEND, d); chk("R2 pend bit0 ignored", d, 32'h0000_0220);

        // R5: write without ack bit does nothing; ack returns 9 (R6)
        wr(A_VEC, 32'h0000_FFFE);
        rd(A_VEC, d); chk("R5 no-ack write", d, 0);
        wr(A_VEC, 32'h1);
        rd(A_VEC, d); chk("R6 highest index wins", d, 32'(9) << 11);
        rd(A_INSVC, d); chk("R9 insvc set", d, 32'h200);
        chk("R9 lower held off", 32'(irq_o), 0);

        // R11: ack with nothing eligible
        wr(A_VEC, 32'h1);
        rd(A_VEC, d); chk("R11 vector 0", d, 0);
        chk("R11 err raised", 32'(err_irq_o), 1);
        wr(A_INSVC, 32'h1);
        chk("R11 err cleared", 32'(err_irq_o), 0);
        rd(A_INSVC, d); chk("R10 other bits kept", d, 32'h200);
        wr(A_INSVC, 32'h200);
        check_all("d3");

        // R3: masked source excluded from ack
        wr(A_MASK, 32'h0000_0020);
        wr(A_VEC, 32'h1);
        rd(A_VEC, d); chk("R3 masked excluded", d, 32'(5) << 11);
        wr(A_INSVC, 32'h20);

        // R7: promoted source
        wr(A_MASK, 32'h0000_0220);
        wr(A_CFG, 32'hE400_0080 | (32'd5 << 13));
        wr(A_VEC, 32'h1);
        rd(A_VEC, d); chk("R7 promoted wins", d, 32'(5) << 11);
        wr(A_INSVC, 32'h20);

        // R8: channel slot order (slot3=ch1, slot2=ch3, slot1=ch0, slot0=ch2)
        setsrc(32'h3C00_0000);
        wr(A_MASK, 32'hFFFF_FFFE);
        wr(A_CFG, 32'h7200_0080);
        wr(A_VEC, 32'h1);
        rd(A_VEC, d); chk("R8 slot3 channel wins", d, 32'(CB + 1) << 11);
        wr(A_VEC, 32'h1);
        rd(A_VEC, d); chk("R9 nested none higher", d, 0);
        wr(A_INSVC, 32'hFFFF_FFFF);
        check_all("d4");

        // R2: level drop
        setsrc(32'h0);
        check_all("d5");
        chk("R2 level drop irq", 32'(irq_o), 0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 6);
            setsrc($urandom);
            case (op)
                0: wr(A_MASK, $urandom);
                1: wr(A_CFG, {rand_perm(), 24'($urandom)});
                2, 3: wr(A_VEC, 32'($urandom % 2));
                4: wr(A_INSVC, m_insvc & (32'd1 << ($urandom % 32)));
                default: wr(A_INSVC, $urandom);
            endcase
            check_all("rnd");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule